// File: doc/BRIEF.md
# Per-Channel Static-Run Audio Mute Detector

This block sits beside the sample path of a multi-channel audio converter and silences any channel whose data has stopped moving. Every lane carries its own sample word and a valid strobe. A lane counts consecutive valid samples that are static, meaning all bits are zero or all bits are one. When that count reaches the run threshold, the lane's mute flag goes high. The first valid sample that is not static clears the flag and starts the count again from zero.

Each lane keeps its own count, so one lane can be muted while the others still play. A global enable input gates all the flags. When the enable is low no lane mutes, but the counts still run. A single registered mute-control output goes high only when every lane is muted. Lanes are packed side by side on one sample bus. Lane k occupies bits [k*SAMPLE_W +: SAMPLE_W].

Top module: `automute_top`

## Requirements
- R1: A lane's mute flag rises in the cycle after the clock edge that accepts its RUN_LEN-th consecutive static valid sample. The default RUN_LEN is 8192. After only RUN_LEN-1 such samples the flag stays low.
- R2: A sample is static only when all SAMPLE_W bits (24 by default) are 0 or all are 1. Any other value, for example 0x7FFFFF or 0x000100, is not static.
- R3: A valid sample that is not static clears that lane's mute flag in the next cycle. It also restarts the run, so another RUN_LEN static samples are needed to mute the lane again.
- R4: Lanes are independent. Samples on one lane never change the count or the flag of another lane.
- R5: Only cycles with that lane's valid strobe high affect its run. Cycles with the strobe low neither advance the run nor reset it.
- R6: The run count saturates at RUN_LEN. A lane stays muted through any number of further static samples, with no wraparound.
- R7: mute_pin_o is high in a cycle exactly when all lane flags were high in the previous cycle. This is one register stage after the flags.
- R8: An active-low reset, asserted asynchronously, clears all runs, all mute flags and mute_pin_o.
- R9: With automute_en_i low, every flag is low from the next cycle onward, but the runs keep counting. If a lane's run is already complete when the enable returns high, that lane mutes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously by the caller |
| automute_en_i | input | 1 | Global enable for muting |
| sample_valid_i | input | NUM_CH | Per-lane sample strobe |
| sample_i | input | NUM_CH*SAMPLE_W | Packed lane samples; lane k is at bits [k*SAMPLE_W +: SAMPLE_W] |
| mute_o | output | NUM_CH | Per-lane mute flags |
| mute_pin_o | output | 1 | Registered all-lanes-muted output |

## Verification
Each lane flag is due one clock after the edge that accepts the deciding sample or the enable change. The mute pin is due one clock later than the flags. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each flag check comes exactly one edge after its stimulus. Each pin check is taken one further step later. Threshold checks are taken at RUN_LEN-1 samples and again at RUN_LEN samples, so an off-by-one in either direction shows up.

// File: rtl/automute_pkg.sv
package automute_pkg;

  // Default run length before a lane is silenced.
  localparam int unsigned DEF_RUN_LEN  = 8192;
  localparam int unsigned DEF_NUM_CH   = 6;
  localparam int unsigned DEF_SAMPLE_W = 24;

  // Classification of one incoming sample.
  typedef enum logic [1:0] {
    SMP_NONE    = 2'b00,  // no valid sample this cycle
    SMP_STATIC  = 2'b01,  // valid and all-zero or all-one
    SMP_MOVING  = 2'b10   // valid and changing data
  } smp_kind_e;

endpackage

// File: rtl/am_static_detect.sv
module am_static_detect #(
  parameter int unsigned SAMPLE_W = automute_pkg::DEF_SAMPLE_W
) (
  input  logic                     valid_i,
  input  logic [SAMPLE_W-1:0]      sample_i,
  output automute_pkg::smp_kind_e  kind_o
);
  import automute_pkg::*;

  logic all_zero;
  logic all_one;

  assign all_zero = ~|sample_i;
  assign all_one  = &sample_i;

  always_comb begin
    if (!valid_i) begin
      kind_o = SMP_NONE;
    end else if (all_zero || all_one) begin
      kind_o = SMP_STATIC;
    end else begin
      kind_o = SMP_MOVING;
    end
  end

endmodule

// File: rtl/am_run_counter.sv
module am_run_counter #(
  parameter int unsigned RUN_LEN = automute_pkg::DEF_RUN_LEN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  automute_pkg::smp_kind_e  kind_i,
  input  logic                     en_i,
  output logic                     mute_o
);
  import automute_pkg::*;

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             mute_q;
  logic             mute_d;

  // next-state logic
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (kind_i)
      SMP_MOVING: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      SMP_STATIC: begin
        if (cnt_q != LIMIT) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
    mute_d = en_i && (cnt_d == LIMIT);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= 1'b0;
    end else begin
      mute_q <= mute_d;
    end
  end

  assign mute_o = mute_q;

  // R6: count never passes the threshold
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R1: a rising flag is always backed by a full run
  a_r1_mute_needs_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_o) |-> (cnt_q == LIMIT));

  // R3: a moving sample releases the lane
  a_r3_release_on_moving: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == SMP_MOVING) |=> !mute_o);

  // R9: disabled means silent flag
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !mute_o);

  // R5/R6: a muted lane holds while nothing moves and enable stays high
  a_r6_hold_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_o && en_i && kind_i != SMP_MOVING) |=> mute_o);

endmodule

// File: rtl/am_pin_combine.sv
module am_pin_combine #(
  parameter int unsigned NUM_CH = automute_pkg::DEF_NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mute_i,
  output logic              pin_o
);

  logic pin_q;
  logic pin_d;

  always_comb begin
    pin_d = &mute_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign pin_o = pin_q;

  // R7: pin rises only after every lane was muted
  a_r7_pin_rise_all_muted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_o) |-> $past(&mute_i));

  // R7: one unmuted lane keeps the pin low next cycle
  a_r7_partial_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_i != '1) |=> !pin_o);

endmodule

// File: rtl/automute_top.sv
module automute_top #(
  parameter int unsigned NUM_CH   = automute_pkg::DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = automute_pkg::DEF_SAMPLE_W,
  parameter int unsigned RUN_LEN  = automute_pkg::DEF_RUN_LEN
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         automute_en_i,
  input  logic [NUM_CH-1:0]            sample_valid_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]   sample_i,
  output logic [NUM_CH-1:0]            mute_o,
  output logic                         mute_pin_o
);
  import automute_pkg::*;

  smp_kind_e         kind [NUM_CH];
  logic [NUM_CH-1:0] lane_mute;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    am_static_detect #(
      .SAMPLE_W (SAMPLE_W)
    ) u_detect (
      .valid_i  (sample_valid_i[g]),
      .sample_i (sample_i[g*SAMPLE_W +: SAMPLE_W]),
      .kind_o   (kind[g])
    );

    am_run_counter #(
      .RUN_LEN (RUN_LEN)
    ) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind_i (kind[g]),
      .en_i   (automute_en_i),
      .mute_o (lane_mute[g])
    );

    // R4: an idle lane keeps its flag unchanged
    a_r4_idle_lane_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_valid_i[g] && automute_en_i && $past(automute_en_i)) |=> $stable(lane_mute[g]));
  end

  am_pin_combine #(
    .NUM_CH (NUM_CH)
  ) u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .mute_i (lane_mute),
    .pin_o  (mute_pin_o)
  );

  assign mute_o = lane_mute;

endmodule

// File: tb/automute_top_tb.sv
module automute_top_tb;

  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int RL  = 8192;
  localparam logic [NCH-1:0] ALL = '1;

  logic               clk;
  logic               rst_n;
  logic               en;
  logic [NCH-1:0]     vld;
  logic [NCH*SW-1:0]  smp;
  logic [NCH-1:0]     mute;
  logic               pin;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  automute_top #(.NUM_CH(NCH), .SAMPLE_W(SW), .RUN_LEN(RL)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .automute_en_i  (en),
    .sample_valid_i (vld),
    .sample_i       (smp),
    .mute_o         (mute),
    .mute_pin_o     (pin)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_mute(input string req, input logic [NCH-1:0] exp);
    chk(mute === exp, req, int'(mute), int'(exp));
  endtask

  task automatic chk_pin(input string req, input logic exp);
    chk(pin === exp, req, int'(pin), int'(exp));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic feed(input int n, input logic [NCH-1:0] mask);
    vld = mask;
    repeat (n) step();
    vld = '0;
  endtask

  task automatic set_all(input logic [SW-1:0] v);
    for (int k = 0; k < NCH; k++) smp[k*SW +: SW] = v;
  endtask

  task automatic do_reset();
    en    = 1'b1;
    vld   = '0;
    set_all('0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_mute("R8 reset flags", '0);
    chk_pin("R8 reset pin", 1'b0);
  endtask

  task automatic t_zero_threshold();
    do_reset();
    feed(RL - 1, ALL);
    chk_mute("R1 one short of run", '0);
    feed(1, ALL);
    chk_mute("R1 full zero run", ALL);
    chk_pin("R7 pin one cycle behind", 1'b0);
    step();
    chk_pin("R7 pin high all muted", 1'b1);
  endtask

  task automatic t_release();
    smp[2*SW +: SW] = 24'h000100;
    feed(1, NCH'(1) << 2);
    chk_mute("R3 R4 lane 2 released only", 6'h3b);
    step();
    chk_pin("R7 pin drops with one lane free", 1'b0);
    smp[2*SW +: SW] = '0;
    feed(RL - 1, NCH'(1) << 2);
    chk_mute("R3 run restarted", 6'h3b);
    feed(1, NCH'(1) << 2);
    chk_mute("R3 remute after new run", ALL);
  endtask

  task automatic t_ones();
    do_reset();
    set_all('1);
    smp[5*SW +: SW] = 24'h7FFFFF;
    feed(RL, ALL);
    chk_mute("R2 all-ones static, 7FFFFF not", 6'h1f);
    step();
    chk_pin("R7 pin low with lane 5 live", 1'b0);
  endtask

  task automatic t_gating();
    do_reset();
    feed(8000, ALL);
    repeat (500) step();
    chk_mute("R5 idle cycles do not count", '0);
    feed(RL - 8000 - 1, ALL);
    chk_mute("R5 idle cycles kept run", '0);
    feed(1, ALL);
    chk_mute("R5 run completes across gaps", ALL);
  endtask

  task automatic t_saturate();
    feed(10000, ALL);
    chk_mute("R6 no wrap after long run", ALL);
    step();
    chk_pin("R6 pin still high", 1'b1);
  endtask

  task automatic t_enable();
    en = 1'b0;
    step();
    chk_mute("R9 disable releases next clock", '0);
    step();
    chk_pin("R9 pin low when disabled", 1'b0);
    feed(5, ALL);
    chk_mute("R9 stays quiet while disabled", '0);
    en = 1'b1;
    step();
    chk_mute("R9 re-enable mutes completed runs", ALL);
    do_reset();
    en = 1'b0;
    feed(RL, ALL);
    chk_mute("R9 no mute while disabled", '0);
    en = 1'b1;
    step();
    chk_mute("R9 count ran while disabled", ALL);
  endtask

  task automatic t_midreset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_mute("R8 async clear flags", '0);
    chk_pin("R8 async clear pin", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    feed(RL - 1, ALL);
    chk_mute("R8 run cleared by reset", '0);
  endtask

  task automatic t_independent();
    do_reset();
    for (int i = 0; i < RL; i++) begin
      smp[0 +: SW] = (i % 100 == 99) ? 24'h123456 : 24'h0;
      vld = ALL;
      step();
    end
    vld = '0;
    chk_mute("R4 lanes independent", 6'h3e);
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    rst_n = 1'b0;
    en    = 1'b1;
    vld   = '0;
    smp   = '0;
    @(negedge clk);
    t_reset_state();
    t_zero_threshold();
    t_release();
    t_ones();
    t_gating();
    t_saturate();
    t_enable();
    t_midreset();
    t_independent();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule